// File: doc/BRIEF.md
# Key Event FIFO with Peek Read

This block keeps a small circular store of keypad events for a command controller. A key event port delivers a key code and a press/release flag. The block packs them into one byte, with the flag in the top bit, and appends the byte to the store. The controller reads events back through a read port that has two modes:

- A consuming read moves the start pointer forward by one and returns the entry found at the new start.
- A peek read returns the entry at a byte offset from the current start and moves nothing.

The consuming read always keeps the most recently serviced entry in the store. So a peek at offset zero returns the event that was handled last.

The block also keeps three flags:

- A keypad-event flag, set on every stored event.
- An error-status flag, set when a push arrives while the store is full.
- A sticky overflow flag, set at the same time as the error-status flag.

While the overflow and error-status flags are both set, new events are dropped without any further effect. An acknowledge input clears the keypad-event and error-status flags. A clear input empties the store and clears those same two flags. The configuration path drives the clear input when it rewrites the setup.

Top module: `keyq_top`

## Requirements
- R1: After reset the fill level is 0, the read data is 0x00, and all three flags are 0.
- R2: An accepted push stores the byte {press, code} (press flag in bit 7, key code in bits 6:0) at position (start + fill) mod 16. It raises the fill by one and sets the keypad-event flag.
- R3: A consuming read (rd_peek_i = 0) with a fill of 1 or less returns 0x00 and changes no pointer.
- R4: A consuming read with a fill of 2 or more advances start by one (mod 16) and lowers the fill by one. It returns the entry at the new start.
- R5: A peek read (rd_peek_i = 1) at index i returns 0x00 when i is not below the fill. Otherwise it returns the entry at (start + i) mod 16. A peek changes no pointer.
- R6: A push that arrives with 16 entries held is dropped, and the entry already at that position is left as it was. It sets the overflow flag and the error-status flag, and the fill stays at 16.
- R7: While the overflow flag and the error-status flag are both 1, a push stores nothing and changes neither the fill nor any flag.
- R8: ack_i clears the keypad-event flag and the error-status flag. The overflow flag stays set until reset.
- R9: clr_i sets start and fill to 0 and clears the keypad-event and error-status flags. It takes priority over a push or a read in the same cycle, and a read in that cycle returns 0x00.
- R10: A push and a consuming read that are both accepted in one cycle leave the fill unchanged, and both take effect.
- R11: Read data is registered: it updates on the edge that takes a read request and holds its value in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Empty the store and clear the event and error-status flags |
| ack_i | input | 1 | Clear the keypad-event and error-status flags |
| ev_valid_i | input | 1 | Key event present this cycle |
| ev_code_i | input | CODE_W (7) | Key code |
| ev_press_i | input | 1 | Press (1) or release (0) flag |
| rd_req_i | input | 1 | Read request |
| rd_peek_i | input | 1 | 0 = consuming read, 1 = peek read |
| rd_idx_i | input | IDX_W (8) | Byte index for a peek read |
| rd_data_o | output | CODE_W+1 (8) | Read result, registered |
| fill_o | output | log2(DEPTH)+1 (5) | Current number of held entries |
| kp_flag_o | output | 1 | Keypad-event flag |
| err_flag_o | output | 1 | Error-status flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: DEPTH 16, CODE_W 7, IDX_W 8 and registered read data. A depth of 16 is small enough to fill the store, force an overflow, and wrap the write position back to slot 0 within a few dozen cycles. An 8-bit index lets peek reads reach offsets at and beyond the fill, so the out-of-range zero result can be tested. The registered read path gives every result a fixed one-edge latency, which lets the bench check that data is held between requests.

// File: rtl/keyq_pkg.sv
package keyq_pkg;

   typedef enum logic {
      RD_POP  = 1'b0,
      RD_PEEK = 1'b1
   } rd_kind_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata_a = mem_q[raddr_a];
   assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/keyq_ptr.sv
module keyq_ptr #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic          suppress,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          ovf_evt,
   output logic [AW-1:0] start_o,
   output logic [AW-1:0] waddr_o,
   output logic [LW-1:0] len_o
);

   logic [AW-1:0] start_q, start_d;
   logic [LW-1:0] len_q, len_d;
   logic          full;

   assign full    = (len_q == LW'(DEPTH));
   assign push_ok = push_req & ~clr & ~suppress & ~full;
   assign ovf_evt = push_req & ~clr & ~suppress & full;
   assign pop_ok  = pop_req & ~clr & (len_q > LW'(1));

   always_comb begin
      start_d = start_q;
      len_d   = len_q;
      if (clr) begin
         start_d = '0;
         len_d   = '0;
      end else begin
         if (pop_ok) start_d = start_q + AW'(1);
         unique case ({push_ok, pop_ok})
            2'b10:   len_d = len_q + LW'(1);
            2'b01:   len_d = len_q - LW'(1);
            default: len_d = len_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         len_q   <= '0;
      end else begin
         start_q <= start_d;
         len_q   <= len_d;
      end
   end

   assign start_o = start_q;
   assign waddr_o = start_q + len_q[AW-1:0];
   assign len_o   = len_q;

   // R6
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LW'(DEPTH));

   // R9
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (len_q == '0 && start_q == '0));

   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !pop_ok) |=> (len_q == $past(len_q) + LW'(1)));

   // R10
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(len_q));

endmodule

// File: rtl/keyq_flags.sv
module keyq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ack,
   input  logic push_ok,
   input  logic ovf_evt,
   output logic kp_o,
   output logic err_o,
   output logic ovf_o,
   output logic suppress_o
);

   logic kp_q, err_q, ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kp_q  <= 1'b0;
         err_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (clr)          kp_q <= 1'b0;
         else if (push_ok) kp_q <= 1'b1;
         else if (ack)     kp_q <= 1'b0;

         if (clr)          err_q <= 1'b0;
         else if (ovf_evt) err_q <= 1'b1;
         else if (ack)     err_q <= 1'b0;

         if (ovf_evt)      ovf_q <= 1'b1;
      end
   end

   assign kp_o       = kp_q;
   assign err_o      = err_q;
   assign ovf_o      = ovf_q;
   assign suppress_o = ovf_q & err_q;

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);

   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !push_ok && !ovf_evt) |=> (!kp_q && !err_q));

endmodule

// File: rtl/keyq_top.sv
module keyq_top #(
   parameter int DEPTH     = 16,
   parameter int CODE_W    = 7,
   parameter int IDX_W     = 8,
   parameter bit REG_RDATA = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int LW       = AW + 1,
   localparam int DW       = CODE_W + 1,
   localparam int CW       = (IDX_W > LW) ? IDX_W : LW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ack_i,
   input  logic              ev_valid_i,
   input  logic [CODE_W-1:0] ev_code_i,
   input  logic              ev_press_i,
   input  logic              rd_req_i,
   input  logic              rd_peek_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DW-1:0]     rd_data_o,
   output logic [LW-1:0]     fill_o,
   output logic              kp_flag_o,
   output logic              err_flag_o,
   output logic              ovf_flag_o
);
   import keyq_pkg::*;

   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("keyq_top: DEPTH must be a power of two of at least 2");
   end
   if (IDX_W < AW) begin : g_bad_idx
      $error("keyq_top: IDX_W must cover the address width");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("keyq_top: CODE_W must be at least 1");
   end

   rd_kind_e      kind;
   logic          push_ok, pop_ok, ovf_evt, suppress;
   logic [AW-1:0] start, waddr, pop_addr, peek_addr;
   logic [LW-1:0] len;
   logic [DW-1:0] pop_data, peek_data, rd_next;
   logic [CW-1:0] idx_ext, len_ext;
   logic          peek_hit;

   assign kind = rd_kind_e'(rd_peek_i);

   keyq_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_i),
      .push_req (ev_valid_i),
      .pop_req  (rd_req_i && kind == RD_POP),
      .suppress (suppress),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .ovf_evt  (ovf_evt),
      .start_o  (start),
      .waddr_o  (waddr),
      .len_o    (len)
   );

   keyq_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr_i),
      .ack        (ack_i),
      .push_ok    (push_ok),
      .ovf_evt    (ovf_evt),
      .kp_o       (kp_flag_o),
      .err_o      (err_flag_o),
      .ovf_o      (ovf_flag_o),
      .suppress_o (suppress)
   );

   assign pop_addr  = start + AW'(1);
   assign peek_addr = start + rd_idx_i[AW-1:0];

   keyq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .we      (push_ok),
      .waddr   (waddr),
      .wdata   ({ev_press_i, ev_code_i}),
      .raddr_a (pop_addr),
      .rdata_a (pop_data),
      .raddr_b (peek_addr),
      .rdata_b (peek_data)
   );

   assign idx_ext  = CW'(rd_idx_i);
   assign len_ext  = CW'(len);
   assign peek_hit = idx_ext < len_ext;

   always_comb begin
      rd_next = '0;
      if (!clr_i) begin
         if (kind == RD_POP) rd_next = pop_ok ? pop_data : '0;
         else                rd_next = peek_hit ? peek_data : '0;
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      logic [DW-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rd_q <= '0;
         else if (rd_req_i) rd_q <= rd_next;
      end
      assign rd_data_o = rd_q;

      // R11
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_req_i |=> $stable(rd_data_o));

      // R3
      short_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req_i && !rd_peek_i && !clr_i && fill_o <= LW'(1))
         |=> (rd_data_o == '0 && $stable(fill_o)));

      // R5
      peek_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req_i && rd_peek_i && !clr_i && !ev_valid_i && CW'(rd_idx_i) >= CW'(fill_o))
         |=> (rd_data_o == '0 && $stable(fill_o)));
   end else begin : g_rd_comb
      assign rd_data_o = rd_req_i ? rd_next : '0;
   end

   assign fill_o = len;

   // R7
   suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && err_flag_o && ev_valid_i && !rd_req_i && !clr_i && !ack_i)
      |=> ($stable(fill_o) && $stable(kp_flag_o)));

endmodule

// File: tb/sim_keyq_top.sv
`timescale 1ns/1ps
module sim_keyq_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0, ack_i = 1'b0, ev_valid_i = 1'b0, ev_press_i = 1'b0;
   logic [6:0] ev_code_i = '0;
   logic       rd_req_i = 1'b0, rd_peek_i = 1'b0;
   logic [7:0] rd_idx_i = '0;
   logic [7:0] rd_data_o;
   logic [4:0] fill_o;
   logic       kp_flag_o, err_flag_o, ovf_flag_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   keyq_top u0 (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .ack_i(ack_i),
      .ev_valid_i(ev_valid_i), .ev_code_i(ev_code_i), .ev_press_i(ev_press_i),
      .rd_req_i(rd_req_i), .rd_peek_i(rd_peek_i), .rd_idx_i(rd_idx_i),
      .rd_data_o(rd_data_o), .fill_o(fill_o),
      .kp_flag_o(kp_flag_o), .err_flag_o(err_flag_o), .ovf_flag_o(ovf_flag_o)
   );

   typedef struct packed {
      logic       push;
      logic [6:0] code;
      logic       press;
      logic       rd;
      logic       peek;
      logic [7:0] idx;
      logic [4:0] elen;
      logic [7:0] edata;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 7'h3c, 1'b0, 1'b0, 1'b0, 8'd0, 5'd1, 8'h00},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 5'd1, 8'h00},
      '{1'b1, 7'h55, 1'b1, 1'b0, 1'b0, 8'd0, 5'd2, 8'h00},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd0, 5'd2, 8'h3c},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd1, 5'd2, 8'hd5},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd2, 5'd2, 8'h00},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 5'd1, 8'hd5},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd0, 5'd1, 8'hd5},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 5'd1, 8'h00},
      '{1'b1, 7'h01, 1'b0, 1'b0, 1'b0, 8'd0, 5'd2, 8'h00},
      '{1'b1, 7'h7f, 1'b1, 1'b1, 1'b0, 8'd0, 5'd2, 8'h01},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd1, 5'd2, 8'hff},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd0, 5'd2, 8'h01},
      '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd9, 5'd2, 8'h00}
   };

   task automatic chk(input string req, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
      end
   endtask

   task automatic op(input logic push, input logic [6:0] code, input logic press,
                     input logic rd, input logic peek, input logic [7:0] idx,
                     input logic clr, input logic ack);
      ev_valid_i = push; ev_code_i = code; ev_press_i = press;
      rd_req_i = rd; rd_peek_i = peek; rd_idx_i = idx;
      clr_i = clr; ack_i = ack;
      @(negedge clk);
      ev_valid_i = 1'b0; rd_req_i = 1'b0; clr_i = 1'b0; ack_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 fill", fill_o, 0);
      chk("R1 data", rd_data_o, 0);
      chk("R1 flags", {kp_flag_o, err_flag_o, ovf_flag_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R5 R10 R11
      for (int i = 0; i < NV; i++) begin
         op(TBL[i].push, TBL[i].code, TBL[i].press, TBL[i].rd, TBL[i].peek,
            TBL[i].idx, 1'b0, 1'b0);
         chk($sformatf("R2/R4/R10 row %0d fill", i), fill_o, TBL[i].elen);
         chk($sformatf("R3/R5/R11 row %0d data", i), rd_data_o, TBL[i].edata);
      end
      chk("R2 kp flag", kp_flag_o, 1);

      // R9 clear alone
      op(1'b0, 7'h0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0);
      chk("R9 fill", fill_o, 0);
      chk("R9 kp", kp_flag_o, 0);

      // fill to 16
      for (int k = 0; k < 16; k++)
         op(1'b1, 7'h40 + 7'(k), k[0], 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R2 full fill", fill_o, 16);
      chk("R2 full flags", {kp_flag_o, err_flag_o, ovf_flag_o}, 3'b100);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd15, 1'b0, 1'b0);
      chk("R5 peek 15", rd_data_o, 8'hcf);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0);
      chk("R5 peek 0", rd_data_o, 8'h40);

      // R6 overflow
      op(1'b1, 7'h11, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R6 fill", fill_o, 16);
      chk("R6 err/ovf", {err_flag_o, ovf_flag_o}, 2'b11);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd15, 1'b0, 1'b0);
      chk("R6 not stored", rd_data_o, 8'hcf);

      // R4 pop from full
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R4 pop data", rd_data_o, 8'hc1);
      chk("R4 pop fill", fill_o, 15);

      // R7 suppressed push
      op(1'b1, 7'h33, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R7 fill", fill_o, 15);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd14, 1'b0, 1'b0);
      chk("R7 slot kept", rd_data_o, 8'hcf);

      // R8 ack
      op(1'b0, 7'h0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
      chk("R8 flags", {kp_flag_o, err_flag_o, ovf_flag_o}, 3'b001);

      // R2 wrap write to slot 0
      op(1'b1, 7'h22, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R2 wrap fill", fill_o, 16);
      chk("R2 wrap kp", kp_flag_o, 1);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd15, 1'b0, 1'b0);
      chk("R2 wrap data", rd_data_o, 8'h22);

      // R9 clear wins over push and pop
      op(1'b1, 7'h05, 1'b1, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0);
      chk("R9 prio fill", fill_o, 0);
      chk("R9 prio data", rd_data_o, 0);
      chk("R9 prio flags", {kp_flag_o, err_flag_o, ovf_flag_o}, 3'b001);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0);
      chk("R5 empty peek", rd_data_o, 0);

      // R7 suppression needs both flags
      op(1'b1, 7'h0a, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R7 accepted fill", fill_o, 1);
      chk("R7 accepted kp", kp_flag_o, 1);
      op(1'b0, 7'h0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0);
      chk("R2 stored byte", rd_data_o, 8'h8a);

      // R11 hold without request
      op(1'b0, 7'h0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
      chk("R11 hold", rd_data_o, 8'h8a);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule